// File: doc/BRIEF.md
# Memory Access Integrity Monitor

A passive observer placed next to a byte-addressed data memory. On every cycle where a read or write strobe is high, it examines the access and flags suspicious behaviour: touching address zero, reading a page or a byte that has never been stored to, and popping a return address whose bytes were overwritten after the call pushed them. It holds its own shadow state for this. There is one written bit per byte, one written bit per page, and one provenance tag per byte that records whether the byte was last stored by a call push.

Each of the four categories has its own policy: ignore, warn or error. A policy can be written for one category, or one command can force the same policy onto all four. A warning is a one-cycle pulse carrying a category code. An error latches a halt output and freezes the code of the category that caused it. The memory contents are outside this block, and so is any reporting to a host.

Top module: `mem_integrity_mon`

## Requirements
- R1: After reset, `warn_o`, `code_o`, `halt_o` and `halt_code_o` are 0. Every category policy is warn (2'b01). Every byte, page and call tag is unwritten or clear.
- R2: Any read or write with `addr_i` equal to 0 fires category 0 (null).
- R3: A read fires category 1 (unwritten page) when any byte it covers lies in a page (`addr_i >> PAGE_W`) that no store has touched since reset.
- R4: A read fires category 2 (unwritten byte) when any byte it covers has not been stored since reset.
- R5: A read with `ret_pop_i` high fires category 3 (corrupt stack) when any covered byte was not last written by a store with `call_push_i` high. A call push sets the tag on each byte it writes. An ordinary store clears it.
- R6: `size_i` 2'b00, 2'b01 and 2'b10 or 2'b11 cover 1, 2 and 4 bytes from `addr_i` upward, wrapping modulo the shadow space. All covered bytes are checked and updated.
- R7: Categories whose policy is ignore are dropped. Among the remaining fired categories, the lowest code is reported and its policy decides the action.
- R8: `set_we_i` writes `set_val_i` into the policy of category `set_cat_i`. Encoding: 2'b00 ignore, 2'b01 warn, 2'b10 error, and 2'b11 behaves as ignore.
- R9: `all_we_i` writes `all_val_i` into all four policies. It overrides a `set_we_i` in the same cycle.
- R10: A warn outcome raises `warn_o` with `code_o` for exactly the cycle after the access. Otherwise `warn_o` and `code_o` are 0.
- R11: An error outcome sets `halt_o` and `halt_code_o` in the cycle after the access. Both hold until reset, and no warning is reported while halted.
- R12: A cycle with neither strobe high produces no warning and does not change the halt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| size_i | input | 2 | Access size code |
| call_push_i | input | 1 | Store is a call pushing the program counter |
| ret_pop_i | input | 1 | Load is a return fetching the saved program counter |
| set_we_i | input | 1 | Write one category policy |
| set_cat_i | input | 2 | Category selected by set_we_i |
| set_val_i | input | 2 | Policy value for set_we_i |
| all_we_i | input | 1 | Write all category policies |
| all_val_i | input | 2 | Policy value for all_we_i |
| warn_o | output | 1 | One-cycle warning pulse |
| code_o | output | 2 | Category of the warning |
| halt_o | output | 1 | Sticky error halt |
| halt_code_o | output | 2 | Category that caused the halt |

## Verification
Properties checked on every cycle: the halt flag and its code never change once set, warnings and halt never show together, idle cycles leave both untouched, an access to address zero under a warn policy yields a category-0 pulse, a global policy command lands in all four policies, and every store marks its first byte written. Only the bench's scenarios can show the shadow-state behaviour over time. That covers page and byte provenance across wrapped multi-byte accesses, the tag being set by a call push and cleared by a later plain store, lowest-code selection after some categories are made ignore, and a reset that wipes the shadow history. A reference model in the bench tracks these across directed cases and a long seeded random run.

// File: rtl/mim_pkg.sv
package mim_pkg;
  localparam int NCAT = 4;
  localparam logic [1:0] POL_IGNORE = 2'b00;
  localparam logic [1:0] POL_WARN   = 2'b01;
  localparam logic [1:0] POL_ERROR  = 2'b10;
  localparam logic [1:0] CAT_NULL   = 2'd0;
  localparam logic [1:0] CAT_PAGE   = 2'd1;
  localparam logic [1:0] CAT_BYTE   = 2'd2;
  localparam logic [1:0] CAT_STACK  = 2'd3;
  typedef logic [NCAT-1:0]   cat_vec_t;
  typedef logic [2*NCAT-1:0] pol_vec_t;
endpackage

// File: rtl/mim_shadow.sv
module mim_shadow
  import mim_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic [LANES-1:0]  byte_wr_o,
  output logic [LANES-1:0]  tag_o,
  output logic [LANES-1:0]  page_wr_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPAGE = 1 << (ADDR_W - PAGE_W);

  logic [DEPTH-1:0]  wr_q, tag_q;
  logic [NPAGE-1:0]  pg_q;
  logic [ADDR_W-1:0] lane_addr [LANES];
  logic [2:0]        nbytes;

  always_comb begin
    case (size_i)
      2'b00:   nbytes = 3'd1;
      2'b01:   nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_addr[l] = addr_i + ADDR_W'(l);
    assign lane_en_o[l] = (3'(l) < nbytes);
    assign byte_wr_o[l] = wr_q[lane_addr[l]];
    assign tag_o[l]     = tag_q[lane_addr[l]];
    assign page_wr_o[l] = pg_q[lane_addr[l][ADDR_W-1:PAGE_W]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      tag_q <= '0;
      pg_q  <= '0;
    end else if (wr_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en_o[l]) begin
          wr_q[lane_addr[l]]                 <= 1'b1;
          tag_q[lane_addr[l]]                <= call_i;
          pg_q[lane_addr[l][ADDR_W-1:PAGE_W]] <= 1'b1;
        end
      end
    end
  end

  assert_store_marks_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> wr_q[$past(addr_i)]);
  assert_push_tags_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && call_i) |=> tag_q[$past(addr_i)]);
endmodule

// File: rtl/mim_policy.sv
module mim_policy
  import mim_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_we_i,
  input  logic [1:0] set_cat_i,
  input  logic [1:0] set_val_i,
  input  logic     all_we_i,
  input  logic [1:0] all_val_i,
  output pol_vec_t pol_o
);
  logic [1:0] pol_q [NCAT];

  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  pol_q[c] <= POL_WARN;
      else if (all_we_i)                            pol_q[c] <= all_val_i;
      else if (set_we_i && set_cat_i == 2'(c))      pol_q[c] <= set_val_i;
    end
    assign pol_o[2*c +: 2] = pol_q[c];
  end

  assert_global_sets_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_we_i |=> (pol_o == {NCAT{$past(all_val_i)}}));
endmodule

// File: rtl/mim_report.sv
module mim_report
  import mim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cat_vec_t   fired_i,
  input  pol_vec_t   pol_i,
  output logic       warn_o,
  output logic [1:0] code_o,
  output logic       halt_o,
  output logic [1:0] halt_code_o
);
  cat_vec_t   active;
  logic [1:0] sel, sel_pol;

  for (genvar c = 0; c < NCAT; c++) begin : g_act
    assign active[c] = fired_i[c] &&
      (pol_i[2*c +: 2] == POL_WARN || pol_i[2*c +: 2] == POL_ERROR);
  end

  // lowest active category wins
  always_comb begin
    sel = '0;
    for (int c = NCAT-1; c >= 0; c--) if (active[c]) sel = 2'(c);
    sel_pol = pol_i[2*sel +: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_o      <= 1'b0;
      code_o      <= '0;
      halt_o      <= 1'b0;
      halt_code_o <= '0;
    end else begin
      warn_o <= 1'b0;
      code_o <= '0;
      if (!halt_o && |active) begin
        if (sel_pol == POL_ERROR) begin
          halt_o      <= 1'b1;
          halt_code_o <= sel;
        end else begin
          warn_o <= 1'b1;
          code_o <= sel;
        end
      end
    end
  end

  assert_halt_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && $stable(halt_code_o));
  assert_no_warn_when_halted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(warn_o && halt_o));
endmodule

// File: rtl/mem_integrity_mon.sv
module mem_integrity_mon
  import mim_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              call_push_i,
  input  logic              ret_pop_i,
  input  logic              set_we_i,
  input  logic [1:0]        set_cat_i,
  input  logic [1:0]        set_val_i,
  input  logic              all_we_i,
  input  logic [1:0]        all_val_i,
  output logic              warn_o,
  output logic [1:0]        code_o,
  output logic              halt_o,
  output logic [1:0]        halt_code_o
);
  localparam int LANES = 4;

  logic [LANES-1:0] lane_en, byte_wr, tag, page_wr;
  cat_vec_t         fired;
  pol_vec_t         pol;

  mim_shadow #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LANES(LANES)) i_shadow (
    .clk_i, .rst_ni, .wr_i, .call_i(call_push_i), .addr_i, .size_i,
    .lane_en_o(lane_en), .byte_wr_o(byte_wr), .tag_o(tag), .page_wr_o(page_wr)
  );

  mim_policy i_policy (
    .clk_i, .rst_ni, .set_we_i, .set_cat_i, .set_val_i, .all_we_i, .all_val_i,
    .pol_o(pol)
  );

  assign fired[CAT_NULL]  = (rd_i || wr_i) && (addr_i == '0);
  assign fired[CAT_PAGE]  = rd_i && |(lane_en & ~page_wr);
  assign fired[CAT_BYTE]  = rd_i && |(lane_en & ~byte_wr);
  assign fired[CAT_STACK] = rd_i && ret_pop_i && |(lane_en & ~tag);

  mim_report i_report (
    .clk_i, .rst_ni, .fired_i(fired), .pol_i(pol),
    .warn_o, .code_o, .halt_o, .halt_code_o
  );

  assert_null_warns_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && addr_i == '0 && pol[1:0] == POL_WARN && !halt_o)
      |=> (warn_o && code_o == CAT_NULL));
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> (!warn_o && $stable(halt_o)));
  assert_error_halts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && addr_i == '0 && pol[1:0] == POL_ERROR) |=> halt_o);
endmodule

// File: tb/test_mem_integrity_mon.sv
module test_mem_integrity_mon;
  localparam int AW = 10, PW = 6, DEPTH = 1 << AW, NPG = 1 << (AW - PW);

  logic clk = 0, rst_ni = 0;
  logic rd_i = 0, wr_i = 0, call_push_i = 0, ret_pop_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0] size_i = '0;
  logic set_we_i = 0, all_we_i = 0;
  logic [1:0] set_cat_i = '0, set_val_i = '0, all_val_i = '0;
  logic warn_o, halt_o;
  logic [1:0] code_o, halt_code_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit m_wr [DEPTH];
  bit m_tag [DEPTH];
  bit m_pg [NPG];
  logic [1:0] m_pol [4];
  bit m_halt;
  logic [1:0] m_hcode;

  always #10 clk = ~clk;

  mem_integrity_mon #(.ADDR_W(AW), .PAGE_W(PW)) i_mem_integrity_mon (
    .clk_i(clk), .rst_ni, .rd_i, .wr_i, .addr_i, .size_i, .call_push_i, .ret_pop_i,
    .set_we_i, .set_cat_i, .set_val_i, .all_we_i, .all_val_i,
    .warn_o, .code_o, .halt_o, .halt_code_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit on(int c);
    return m_pol[c] == 2'b01 || m_pol[c] == 2'b10;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_wr[i] = 0; m_tag[i] = 0; end
    for (int i = 0; i < NPG; i++) m_pg[i] = 0;
    for (int c = 0; c < 4; c++) m_pol[c] = 2'b01;
    m_halt = 0; m_hcode = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    model_reset();
    @(negedge clk); rst_ni = 1;
    chk("R1 warn", warn_o, 0); chk("R1 code", code_o, 0);
    chk("R1 halt", halt_o, 0); chk("R1 halt_code", halt_code_o, 0);
  endtask

  task automatic acc(string req, bit rd, bit wr, int addr, logic [1:0] sz, bit call, bit ret);
    bit [3:0] f;
    int e_warn = 0, e_code = 0, sel = -1;
    int n = nbytes(sz);
    f = '0;
    if ((rd || wr) && (addr % DEPTH) == 0) f[0] = 1;
    for (int l = 0; l < n; l++) begin
      int a = (addr + l) % DEPTH;
      if (rd && !m_pg[a >> PW]) f[1] = 1;
      if (rd && !m_wr[a]) f[2] = 1;
      if (rd && ret && !m_tag[a]) f[3] = 1;
    end
    for (int c = 3; c >= 0; c--) if (f[c] && on(c)) sel = c;
    if (sel >= 0 && !m_halt) begin
      if (m_pol[sel] == 2'b10) begin m_halt = 1; m_hcode = 2'(sel); end
      else begin e_warn = 1; e_code = sel; end
    end
    if (wr)
      for (int l = 0; l < n; l++) begin
        int a = (addr + l) % DEPTH;
        m_wr[a] = 1; m_tag[a] = call; m_pg[a >> PW] = 1;
      end
    @(negedge clk);
    rd_i = rd; wr_i = wr; addr_i = AW'(addr); size_i = sz; call_push_i = call; ret_pop_i = ret;
    @(negedge clk);
    rd_i = 0; wr_i = 0; call_push_i = 0; ret_pop_i = 0;
    chk({req, " warn"}, warn_o, e_warn);
    chk({req, " code"}, code_o, e_code);
    chk({req, " halt"}, halt_o, m_halt);
    chk({req, " halt_code"}, halt_code_o, m_hcode);
  endtask

  task automatic set_pol(int cat, logic [1:0] v);
    @(negedge clk); set_we_i = 1; set_cat_i = 2'(cat); set_val_i = v;
    @(negedge clk); set_we_i = 0;
    m_pol[cat] = v;
  endtask

  task automatic set_all(logic [1:0] v);
    @(negedge clk); all_we_i = 1; all_val_i = v;
    @(negedge clk); all_we_i = 0;
    for (int c = 0; c < 4; c++) m_pol[c] = v;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    acc("R3 unwritten page", 1, 0, 'h080, 2'b00, 0, 0);
    acc("R4 store", 0, 1, 'h081, 2'b00, 0, 0);
    acc("R4 R6 unwritten byte", 1, 0, 'h080, 2'b01, 0, 0);
    acc("R4 store2", 0, 1, 'h080, 2'b00, 0, 0);
    acc("R4 clean read", 1, 0, 'h080, 2'b01, 0, 0);
    acc("R2 null write", 0, 1, 0, 2'b00, 0, 0);
    acc("R6 wrap store", 0, 1, 'h3FE, 2'b10, 0, 0);
    acc("R6 wrap read", 1, 0, 'h3FF, 2'b01, 0, 0);
    acc("R5 push", 0, 1, 'h100, 2'b10, 1, 0);
    acc("R5 clean pop", 1, 0, 'h100, 2'b10, 0, 1);
    acc("R5 overwrite", 0, 1, 'h102, 2'b00, 0, 0);
    acc("R5 corrupt pop", 1, 0, 'h100, 2'b10, 0, 1);
    acc("R5 plain load", 1, 0, 'h100, 2'b10, 0, 0);
    acc("R7 both fire", 1, 0, 'h200, 2'b00, 0, 0);
    set_pol(1, 2'b00);
    acc("R7 R8 page ignored", 1, 0, 'h200, 2'b00, 0, 0);
    set_pol(1, 2'b11);
    acc("R8 code 11 ignores", 1, 0, 'h200, 2'b00, 0, 0);
    @(negedge clk);
    chk("R12 idle warn", warn_o, 0); chk("R12 idle halt", halt_o, 0);
    set_all(2'b00);
    acc("R9 all ignore", 1, 0, 'h200, 2'b00, 0, 1);
    @(negedge clk);
    all_we_i = 1; all_val_i = 2'b01; set_we_i = 1; set_cat_i = 2'd1; set_val_i = 2'b00;
    @(negedge clk); all_we_i = 0; set_we_i = 0;
    for (int c = 0; c < 4; c++) m_pol[c] = 2'b01;
    acc("R9 global wins", 1, 0, 'h200, 2'b00, 0, 0);
    for (int i = 0; i < 500; i++) begin
      int pg, off, a;
      bit rd;
      logic [1:0] sz;
      bit fl;
      case ($urandom % 4) 0: pg = 0; 1: pg = 1; 2: pg = 5; default: pg = 15; endcase
      off = $urandom % 12;
      a = (pg << PW) | off;
      rd = $urandom % 2;
      sz = 2'($urandom % 4);
      fl = ($urandom % 3) == 0;
      acc("R10 random", rd, !rd, a, sz, !rd && fl, rd && fl);
    end
    set_pol(0, 2'b10);
    acc("R11 error halt", 0, 1, 0, 2'b00, 0, 0);
    acc("R11 halted no warn", 1, 0, 'h300, 2'b00, 0, 0);
    set_all(2'b10);
    acc("R11 code frozen", 1, 0, 'h340, 2'b10, 0, 1);
    do_reset();
    acc("R1 shadow cleared", 1, 0, 'h080, 2'b00, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule